// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the active settings of a clock synthesizer's dividers: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test select. The settings reach it over one of two competing paths. The parallel path uses a level-sensitive load line. While that line is low, the parallel inputs pass straight to the outputs. When it goes high, the values are frozen. The serial path uses a data/clock pair to fill a 14-bit shift register. A separate strobe then copies the shifted fields into the active settings. That path works only while the parallel load line is high.

All control lines (load line, serial clock, serial data and strobe) are sampled on the system clock `clk_i`. Their edges are found by comparing each sample with the one before. A typical use is to set the divider once through the parallel pins at power-up, with the load line low, then to raise the line. The frequency is later retuned, or a test node selected, through the serial path. The test select can be set only through the serial path. It reads as zero whenever the parallel line is low.

Top module: `clk_cfg_loader`

## Requirements
- R1: While `pload_i` is low, `m_o` and `n_o` equal `par_m_i` and `par_n_i` in the same cycle, and they follow any change of those inputs.
- R2: Once `pload_i` is high, `m_o` and `n_o` hold the parallel values sampled at the last `clk_i` edge at which `pload_i` was low. Later changes on the parallel inputs have no effect.
- R3: A rising edge of `sclk_i`, sampled by `clk_i`, shifts `sdata_i` into bit 0 of the 14-bit shift register, but only when `pload_i` is high. Serial clock edges seen while `pload_i` is low leave the shift register unchanged.
- R4: The stream is sent as T, then N, then M, each field most significant bit first. After 14 shifts, the register bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M.
- R5: A falling edge of `sload_i`, with `pload_i` high, copies the T, N and M fields of the shift register to `t_o`, `n_o` and `m_o` on the next cycle. A rising edge of `sload_i` changes nothing. A falling edge while `pload_i` is low is ignored.
- R6: `t_o` is 0 whenever `pload_i` is low. It stays 0 after the parallel values are captured, until a serial transfer sets it.
- R7: After reset, `m_o`, `n_o`, `t_o` and the shift register are all zero, so `sdo_o` is 0.
- R8: `sdo_o` is bit 13 of the shift register. Further shifts read a written word back in the order it was sent.
- R9: Each control level must be held for at least one `clk_i` period to be seen. Edges are detected by comparing each sample with the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all controls |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pload_i | input | 1 | Parallel load line: transparent while low, holds while high |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide code |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data bit |
| sload_i | input | 1 | Serial transfer strobe; acts on its falling edge |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 2 | Active output divide code |
| t_o | output | 3 | Active test select |
| sdo_o | output | 1 | Shift register most significant bit |

## Verification
The assertions check, on every cycle, the following behaviours:
- **Transparency:** the outputs follow the parallel inputs while the load line is low.
- **Forced test bits:** the test bits are zero while the load line is low.
- **Shift rule:** the register shifts by one on a gated serial clock edge, and is frozen while the load line is low.
- **Transfer:** a strobe falling edge copies the shifted fields into the outputs one cycle later.
- **Hold:** the active values stay put when the load line is high and no transfer occurs.

Only the bench scenarios can show the rest:
- which value is captured when the load line rises in the same cycle as the parallel inputs change;
- the field order of a whole 14-bit stream;
- the read-back order on the shift-out bit;
- that serial activity while the load line is low leaves no trace once the line rises again.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int unsigned M_W  = 9;
  localparam int unsigned N_W  = 2;
  localparam int unsigned T_W  = 3;
  localparam int unsigned SR_W = T_W + N_W + M_W;

  // field order matches the serial stream: T first, M last
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam int unsigned EDGE_SCLK  = 0;
  localparam int unsigned EDGE_SLOAD = 1;
  localparam int unsigned EDGE_W     = 2;
endpackage

// File: rtl/clk_cfg_edge_det.sv
module clk_cfg_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] =  sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] &  prev_q[g];
  end
endmodule

// File: rtl/clk_cfg_shift_reg.sv
module clk_cfg_shift_reg #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] sr_o,
  output logic         dout_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign sr_o   = sr_q;
  assign dout_o = sr_q[W-1];
endmodule

// File: rtl/clk_cfg_active_regs.sv
module clk_cfg_active_regs
  import clk_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pload_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           xfer_i,
  input  cfg_t           ser_cfg_i,
  output cfg_t           cfg_o
);
  cfg_t cfg_q;
  cfg_t par_cfg;

  always_comb begin
    par_cfg.t = '0;
    par_cfg.n = par_n_i;
    par_cfg.m = par_m_i;
  end

  // the parallel path dominates; a serial transfer only lands while pload is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (!pload_i) cfg_q <= par_cfg;
    else if (xfer_i)   cfg_q <= ser_cfg_i;
  end

  assign cfg_o = pload_i ? cfg_q : par_cfg;
endmodule

// File: rtl/clk_cfg_loader.sv
module clk_cfg_loader
  import clk_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pload_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           sdo_o
);
  logic [EDGE_W-1:0] ctl;
  logic [EDGE_W-1:0] ctl_rise;
  logic [EDGE_W-1:0] ctl_fall;
  logic              sclk_rise;
  logic              sload_fall;
  logic [SR_W-1:0]   sr_q;
  cfg_t              ser_cfg;
  cfg_t              act_cfg;

  assign ctl[EDGE_SCLK]  = sclk_i;
  assign ctl[EDGE_SLOAD] = sload_i;

  clk_cfg_edge_det #(.W(EDGE_W)) edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ctl),
    .rise_o (ctl_rise),
    .fall_o (ctl_fall)
  );

  assign sclk_rise  = ctl_rise[EDGE_SCLK];
  assign sload_fall = ctl_fall[EDGE_SLOAD];

  clk_cfg_shift_reg #(.W(SR_W)) shreg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_rise & pload_i),
    .din_i   (sdata_i),
    .sr_o    (sr_q),
    .dout_o  (sdo_o)
  );

  assign ser_cfg = cfg_t'(sr_q);

  clk_cfg_active_regs act_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pload_i   (pload_i),
    .par_m_i   (par_m_i),
    .par_n_i   (par_n_i),
    .xfer_i    (sload_fall),
    .ser_cfg_i (ser_cfg),
    .cfg_o     (act_cfg)
  );

  assign m_o = act_cfg.m;
  assign n_o = act_cfg.n;
  assign t_o = act_cfg.t;
endmodule

// File: rtl/clk_cfg_loader_chk.sv
module clk_cfg_loader_chk
  import clk_cfg_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pload_i,
  input logic [M_W-1:0]  par_m_i,
  input logic [N_W-1:0]  par_n_i,
  input logic            sdata_i,
  input logic [M_W-1:0]  m_o,
  input logic [N_W-1:0]  n_o,
  input logic [T_W-1:0]  t_o,
  input logic [SR_W-1:0] sr_q,
  input logic            sclk_rise,
  input logic            sload_fall
);
  a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_i |-> (m_o == par_m_i && n_o == par_n_i));

  a_r6_test_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_i |-> (t_o == '0));

  a_r3_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && pload_i) |=> (sr_q == {$past(sr_q[SR_W-2:0]), $past(sdata_i)}));

  a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_i |=> $stable(sr_q));

  a_r5_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sload_fall && pload_i) |=> (!pload_i ||
      ({t_o, n_o, m_o} == $past(sr_q))));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_i && !sload_fall) |=> (!pload_i ||
      ($stable(m_o) && $stable(n_o) && $stable(t_o))));
endmodule

bind clk_cfg_loader clk_cfg_loader_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pload_i    (pload_i),
  .par_m_i    (par_m_i),
  .par_n_i    (par_n_i),
  .sdata_i    (sdata_i),
  .m_o        (m_o),
  .n_o        (n_o),
  .t_o        (t_o),
  .sr_q       (sr_q),
  .sclk_rise  (sclk_rise),
  .sload_fall (sload_fall)
);

// File: tb/clk_cfg_loader_tb_top.sv
module clk_cfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pload = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       sload = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       sdo;

  int errs = 0;
  int checks = 0;
  logic [13:0] e_sr = '0;
  logic [8:0]  e_m = '0;
  logic [1:0]  e_n = '0;
  logic [2:0]  e_t = '0;

  always #10 clk = ~clk;

  clk_cfg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pload_i(pload), .par_m_i(par_m), .par_n_i(par_n),
    .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .m_o(m_o), .n_o(n_o), .t_o(t_o), .sdo_o(sdo)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, "m_o", 32'(m_o), 32'(e_m));
    chk(req, "n_o", 32'(n_o), 32'(e_n));
    chk(req, "t_o", 32'(t_o), 32'(e_t));
  endtask

  function automatic logic [13:0] pack_word(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic shift_bit(logic b);
    sdata = b;
    sclk  = 1'b1;
    step();
    if (pload) e_sr = {e_sr[12:0], b};
    sclk = 1'b0;
    step();
  endtask

  task automatic serial_write(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    sload = 1'b1;
    step();
    chk("R5", "rising strobe no effect", {t_o, n_o, m_o}, {e_t, e_n, e_m});
    sload = 1'b0;
    step();
    if (pload) {e_t, e_n, e_m} = e_sr;
    chk_out("R5");
  endtask

  task automatic par_load(logic [8:0] m, logic [1:0] n);
    pload = 1'b0;
    par_m = m;
    par_n = n;
    #1;
    e_m = m; e_n = n; e_t = '0;
    chk_out("R1");
    step();
    pload = 1'b1;
    step();
    chk_out("R2");
    par_m = ~m;
    par_n = ~n;
    step();
    chk_out("R2");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [13:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_out("R7");
    chk("R7", "sdo", 32'(sdo), 0);
    rst_n = 1'b1;
    step();
    chk_out("R7");
    chk("R7", "sdo after reset", 32'(sdo), 0);

    // R4: field positions T=5, N=2, M=0x106
    w = 14'b101_10_100000110;
    serial_write(w);
    chk("R8", "sdo msb after write", 32'(sdo), 1);
    strobe();
    chk("R4", "t field", 32'(t_o), 5);
    chk("R4", "n field", 32'(n_o), 2);
    chk("R4", "m field", 32'(m_o), 32'h106);

    // R8: read back in send order
    w = 14'b011_01_110010101;
    serial_write(w);
    for (int i = 13; i >= 0; i--) begin
      chk("R8", "readback bit", 32'(sdo), 32'(w[i]));
      shift_bit(1'b0);
    end

    // R3/R5: serial activity while pload low is ignored
    w = 14'b110_11_001011010;
    serial_write(w);
    pload = 1'b0;
    par_m = 9'h0a5;
    par_n = 2'b01;
    #1;
    e_m = 9'h0a5; e_n = 2'b01; e_t = '0;
    chk_out("R6");
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    strobe();
    chk_out("R5");
    pload = 1'b1;
    step();
    chk_out("R2");
    strobe();
    chk("R3", "shift ignored while low", {t_o, n_o, m_o}, 32'(w));

    // R6: T reads zero while low and after parallel capture
    chk("R6", "t set serially", 32'(t_o), 6);
    par_load(9'h1ff, 2'b11);
    chk("R6", "t after capture", 32'(t_o), 0);

    // R2/R9: rising pload together with new inputs keeps last sampled low value
    pload = 1'b0; par_m = 9'h033; par_n = 2'b10;
    step();
    pload = 1'b1; par_m = 9'h144; par_n = 2'b01;
    step();
    e_m = 9'h033; e_n = 2'b10; e_t = '0;
    chk_out("R2");

    for (int k = 0; k < 30; k++) begin
      if ($urandom % 2 == 0) begin
        serial_write(14'($urandom));
        strobe();
      end else begin
        par_load(9'($urandom), 2'($urandom));
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule